// File: doc/BRIEF.md
# RF Front-End Serial Control Slave

This block is the slave end of a two-wire RF front-end control bus. A host drives a bus clock and a data line. The block oversamples both on its own system clock, detects the start condition, and decodes the command that follows. It compares the addressed slave ID with the programmable ID held in its own register space, or with the broadcast ID. It checks odd parity on every frame and then carries out a register write, a register read or a register-0 write.

The register space holds three kinds of register. The first is a switch mode register at address 0, updated through a shadow copy and a trigger. The second is a power-mode/trigger register. The third is a set of identity registers, one of which carries the live slave ID. The active mode value and the power-mode field drive the rest of the front end. Every accepted write is also shown as a one-cycle address/data strobe. For reads the block drives the data line through a separate output and enable pair, so the pad itself stays outside the block.

Top module: `rffe_slave`

## Requirements
- R1: A sequence starts only when the data line rises and then falls while the bus clock is low. Data pulses while the bus clock is high start nothing, and bits clocked without a start are ignored.
- R2: Bits are sampled on bus-clock falling edges, MSB first. The header is 4 ID bits, then 8 command bits, then one parity bit that makes the count of ones in the 13 bits odd.
- R3: A header is accepted when its ID equals bits 3:0 of register 0x1F (reset value 4'b1010) or is the broadcast ID 0. The compare follows the register's live contents, so writing 0x1F changes which ID the block answers to.
- R4: A header with a parity error, or with an ID that matches neither value, changes no register.
- R5: Command bits 7:5 = 3'b010 is a register write to the address in bits 4:0. It is followed by 8 data bits and an odd parity bit. A data frame with bad parity is dropped.
- R6: A command with bit 7 = 1 is a register-0 write whose value is {1'b0, command bits 6:0}.
- R7: Command bits 7:5 = 3'b011 is a read. After one bus park cycle the block drives 8 data bits MSB first, then an odd parity bit, each changing after a rising edge. It then drives 0 for one more cycle and releases the line after that cycle's falling edge.
- R8: Under the broadcast ID, only register 0x1C accepts a write. Register-0 writes, reads and writes to any other address are ignored, and nothing is driven.
- R9: Writes to address 0 go to a shadow copy. mode_out takes the shadow value when 0x1C is written with bit 0 = 1 and bit 3 = 0. While 0x1C bit 3 (the mask) is 1, address-0 writes reach mode_out at once. 0x1C reads back as {power mode[7:6], mask bits[5:3], 3'b000}.
- R10: Reset (loss of the I/O supply) restores all defaults: mode_out 0x00, 0x1C = 0x80 (power mode 2'b10), 0x1F = 0x1A, 0x1E = 0x1A, 0x1D = 0x85, data line released.
- R11: The identity registers 0x1D and 0x1E are read-only; writes to them leave their values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset, asserted while the I/O supply is absent |
| sclk | input | 1 | Bus clock from the host |
| sdata_in | input | 1 | Data line as seen at the pad input |
| sdata_out | output | 1 | Value driven onto the data line during reads |
| sdata_oe | output | 1 | Output enable for the data line; low leaves it to the pull-down |
| mode_out | output | 8 | Active switch mode value (register 0) |
| pwr_mode | output | 2 | Power-mode field of register 0x1C |
| wr_stb | output | 1 | One-cycle strobe for each accepted register write |
| wr_addr | output | 5 | Register address of the accepted write |
| wr_data | output | 8 | Data of the accepted write |

## Verification
The bench targets the shadow/trigger path. A design that wrote address 0 straight through would change mode_out before the trigger, and one that ignored the mask would hold a masked write back. It moves the slave ID at run time and then addresses the block with the old and new IDs. A design that compared against a fixed constant would answer the stale ID. It sends broadcast writes, register-0 writes and reads, and flips parity bits in the header and in the data frame. A design that gated too little would change registers or drive the line. Reads are checked bit by bit, including the parity bit, the driven-low park cycle and the release after it, which catches off-by-one bit counts and a missing park.

// File: rtl/rffe_pkg.sv
package rffe_pkg;
  localparam int SID_W    = 4;
  localparam int CMD_W    = 8;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int HDR_BITS = SID_W + CMD_W + 1;
  localparam int DAT_BITS = DATA_W + 1;
  localparam int CNT_W    = $clog2(HDR_BITS + 1);

  localparam logic [SID_W-1:0]  BCAST_SID = '0;
  localparam logic [ADDR_W-1:0] A_MODE    = 5'h00;
  localparam logic [ADDR_W-1:0] A_PMTRIG  = 5'h1C;
  localparam logic [ADDR_W-1:0] A_PROD    = 5'h1D;
  localparam logic [ADDR_W-1:0] A_MANF    = 5'h1E;
  localparam logic [ADDR_W-1:0] A_IDREG   = 5'h1F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WDAT, ST_RPARK, ST_RDRV, ST_RREL
  } seq_st_t;

  typedef enum logic [1:0] {K_NONE, K_REG0, K_WR, K_RD} cmd_kind_t;

  // odd parity: count of ones over data and parity bit is odd
  function automatic logic hdr_par_ok(input logic [HDR_BITS-1:0] f);
    return ^f;
  endfunction

  function automatic logic dat_par_ok(input logic [DAT_BITS-1:0] f);
    return ^f;
  endfunction

  function automatic logic par_fill(input logic [DATA_W-1:0] d);
    return ~^d;
  endfunction

  function automatic cmd_kind_t cmd_kind(input logic [CMD_W-1:0] c);
    if (c[CMD_W-1])                    return K_REG0;
    else if (c[CMD_W-1 -: 3] == 3'b010) return K_WR;
    else if (c[CMD_W-1 -: 3] == 3'b011) return K_RD;
    else                               return K_NONE;
  endfunction
endpackage

// File: rtl/rffe_sync.sv
module rffe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic sig_s,
  output logic rise,
  output logic fall
);
  localparam int CHAIN = STAGES + 1;
  logic [CHAIN-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[CHAIN-2:0], sig_in};
  end

  assign sig_s = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
  assign fall  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/rffe_seq.sv
module rffe_seq
  import rffe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdat_s,
  input  logic              sdat_rise,
  input  logic              sdat_fall,
  input  logic [SID_W-1:0]  usid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_bcast,
  output logic              sdo,
  output logic              sdo_en,
  output logic              seq_start
);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(DAT_BITS - 1);
  localparam logic [CNT_W-1:0] TX_DONE  = CNT_W'(DAT_BITS);

  seq_st_t                st;
  logic                   armed;
  logic [CNT_W-1:0]       cnt;
  logic [HDR_BITS-2:0]    shreg;
  logic [ADDR_W-1:0]      addr_q;
  logic                   bcast_q;
  logic [DAT_BITS-1:0]    tx_q;

  // header view on the cycle of its last bit
  logic [HDR_BITS-1:0] hdr_frame;
  logic [SID_W-1:0]    hdr_sid;
  logic [CMD_W-1:0]    hdr_cmd;
  logic                hdr_bc;
  logic                hdr_ok;
  logic [DAT_BITS-1:0] dat_frame;
  logic                dat_ok;

  assign hdr_frame = {shreg, sdat_s};
  assign hdr_sid   = hdr_frame[HDR_BITS-1 -: SID_W];
  assign hdr_cmd   = hdr_frame[CMD_W:1];
  assign hdr_bc    = (hdr_sid == BCAST_SID);
  assign hdr_ok    = hdr_par_ok(hdr_frame) && (hdr_bc || hdr_sid == usid);
  assign dat_frame = {shreg[DATA_W-1:0], sdat_s};
  assign dat_ok    = dat_par_ok(dat_frame) && (!bcast_q || addr_q == A_PMTRIG);

  // start condition: data rises then falls with the bus clock low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (sclk_s)    armed <= 1'b0;
    else if (sdat_rise) armed <= 1'b1;
    else if (sdat_fall) armed <= 1'b0;
  end

  assign seq_start = armed & sdat_fall & ~sclk_s;
  assign rd_addr   = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      addr_q   <= '0;
      bcast_q  <= 1'b0;
      tx_q     <= '0;
      sdo      <= 1'b0;
      sdo_en   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_bcast <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (seq_start) begin
        st     <= ST_CMD;
        cnt    <= '0;
        sdo    <= 1'b0;
        sdo_en <= 1'b0;
      end else begin
        case (st)
          ST_CMD: if (sclk_fall) begin
            shreg <= {shreg[HDR_BITS-3:0], sdat_s};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_HDR) begin
              st <= ST_IDLE;
              if (hdr_ok) begin
                case (cmd_kind(hdr_cmd))
                  K_REG0: if (!hdr_bc) begin
                    wr_stb   <= 1'b1;
                    wr_addr  <= A_MODE;
                    wr_data  <= {1'b0, hdr_cmd[CMD_W-2:0]};
                    wr_bcast <= 1'b0;
                  end
                  K_WR: begin
                    st      <= ST_WDAT;
                    cnt     <= '0;
                    addr_q  <= hdr_cmd[ADDR_W-1:0];
                    bcast_q <= hdr_bc;
                  end
                  K_RD: if (!hdr_bc) begin
                    st     <= ST_RPARK;
                    addr_q <= hdr_cmd[ADDR_W-1:0];
                  end
                  default: ;
                endcase
              end
            end
          end
          ST_WDAT: if (sclk_fall) begin
            shreg <= {shreg[HDR_BITS-3:0], sdat_s};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_DAT) begin
              st <= ST_IDLE;
              if (dat_ok) begin
                wr_stb   <= 1'b1;
                wr_addr  <= addr_q;
                wr_data  <= dat_frame[DAT_BITS-1:1];
                wr_bcast <= bcast_q;
              end
            end
          end
          ST_RPARK: if (sclk_fall) begin
            tx_q <= {rd_data, par_fill(rd_data)};
            cnt  <= '0;
            st   <= ST_RDRV;
          end
          ST_RDRV: if (sclk_rise) begin
            sdo_en <= 1'b1;
            if (cnt == TX_DONE) begin
              sdo <= 1'b0;
              st  <= ST_RREL;
            end else begin
              sdo  <= tx_q[DAT_BITS-1];
              tx_q <= {tx_q[DAT_BITS-2:0], 1'b0};
              cnt  <= cnt + 1'b1;
            end
          end
          ST_RREL: if (sclk_fall) begin
            sdo_en <= 1'b0;
            st     <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rffe_regs.sv
module rffe_regs
  import rffe_pkg::*;
#(
  parameter logic [SID_W-1:0]  DEF_USID = 4'hA,
  parameter logic [DATA_W-1:0] PROD_ID  = 8'h85,
  parameter logic [9:0]        MANF_ID  = 10'h11A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [SID_W-1:0]  usid,
  output logic [DATA_W-1:0] mode_out,
  output logic [1:0]        pwr_mode
);
  localparam logic [1:0] DEF_PM = 2'b10;

  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] active_q;
  logic [1:0]        pm_q;
  logic [2:0]        mask_q;
  logic [SID_W-1:0]  usid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      pm_q     <= DEF_PM;
      mask_q   <= '0;
      usid_q   <= DEF_USID;
    end else if (wr_stb) begin
      case (wr_addr)
        A_MODE: begin
          shadow_q <= wr_data;
          if (mask_q[0]) active_q <= wr_data;
        end
        A_PMTRIG: begin
          pm_q   <= wr_data[7:6];
          mask_q <= wr_data[5:3];
          if (wr_data[0] && !wr_data[3]) active_q <= shadow_q;
        end
        A_IDREG: usid_q <= wr_data[SID_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:   rd_data = active_q;
      A_PMTRIG: rd_data = {pm_q, mask_q, 3'b000};
      A_PROD:   rd_data = PROD_ID;
      A_MANF:   rd_data = MANF_ID[7:0];
      A_IDREG:  rd_data = {2'b00, MANF_ID[9:8], usid_q};
      default:  rd_data = '0;
    endcase
  end

  assign usid     = usid_q;
  assign mode_out = active_q;
  assign pwr_mode = pm_q;
endmodule

// File: rtl/rffe_slave.sv
module rffe_slave
  import rffe_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [SID_W-1:0]  DEF_USID    = 4'hA,
  parameter logic [DATA_W-1:0] PROD_ID     = 8'h85,
  parameter logic [9:0]        MANF_ID     = 10'h11A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic [DATA_W-1:0] mode_out,
  output logic [1:0]        pwr_mode,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic sclk_s, sclk_rise, sclk_fall;
  logic sdat_s, sdat_rise, sdat_fall;
  logic [SID_W-1:0]  usid;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              wr_bcast;
  logic              seq_start;

  rffe_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .sig_in(sclk),
    .sig_s(sclk_s), .rise(sclk_rise), .fall(sclk_fall)
  );

  rffe_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .sig_in(sdata_in),
    .sig_s(sdat_s), .rise(sdat_rise), .fall(sdat_fall)
  );

  rffe_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sdat_s(sdat_s), .sdat_rise(sdat_rise), .sdat_fall(sdat_fall),
    .usid(usid), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_bcast(wr_bcast), .sdo(sdata_out), .sdo_en(sdata_oe),
    .seq_start(seq_start)
  );

  rffe_regs #(.DEF_USID(DEF_USID), .PROD_ID(PROD_ID), .MANF_ID(MANF_ID)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .usid(usid),
    .mode_out(mode_out), .pwr_mode(pwr_mode)
  );
endmodule

// File: rtl/rffe_slave_chk.sv
module rffe_slave_chk
  import rffe_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sdata_out,
  input logic              sdata_oe,
  input logic [DATA_W-1:0] mode_out,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_bcast,
  input logic              seq_start
);
  // the line is only released after a cycle driven low
  assert_park_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_oe) |-> $past(sdata_out) == 1'b0);

  // the slave never drives while a write is being committed
  assert_no_drive_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> !wr_stb);

  // each accepted write is a single strobe
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // broadcast writes land only on the power-mode/trigger register
  assert_bcast_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_bcast) |-> wr_addr == A_PMTRIG);

  // the active mode only moves right after a committed write
  assert_mode_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_out) |-> $past(wr_stb));

  // a new start condition stops any drive in progress
  assert_start_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !sdata_oe);
endmodule

bind rffe_slave rffe_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
  .mode_out(mode_out), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_bcast(wr_bcast), .seq_start(seq_start)
);

// File: tb/rffe_slave_bench.sv
module rffe_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic sdata_in = 1'b0;
  logic sdata_out, sdata_oe, wr_stb;
  logic [7:0] mode_out, wr_data;
  logic [1:0] pwr_mode;
  logic [4:0] wr_addr;

  localparam int H = 8;

  int total = 0;
  int bad = 0;
  bit settled = 1'b0;
  bit done = 1'b0;
  int m_shadow, m_active, m_pm, m_mask, m_usid;

  always #2 clk = ~clk;

  rffe_slave u_rffe_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .mode_out(mode_out),
    .pwr_mode(pwr_mode), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_shadow = 0; m_active = 0; m_pm = 2; m_mask = 0; m_usid = 10;
  endtask

  function automatic bit even_ones(input int v, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) c += (v >> i) & 1;
    return (c % 2) == 0;
  endfunction

  function automatic int exp_read(input int a);
    case (a)
      0:  return m_active;
      28: return (m_pm << 6) | (m_mask << 3);
      29: return 'h85;
      30: return 'h1A;
      31: return 'h10 | m_usid;
      default: return 0;
    endcase
  endfunction

  task automatic apply(input int a, input int d);
    if (a == 0) begin
      m_shadow = d;
      if (m_mask & 1) m_active = d;
    end else if (a == 28) begin
      m_pm = (d >> 6) & 3;
      m_mask = (d >> 3) & 7;
      if ((d & 1) && !((d >> 3) & 1)) m_active = m_shadow;
    end else if (a == 31) begin
      m_usid = d & 15;
    end
  endtask

  // live comparison of the block's outputs against the model
  always @(negedge clk) begin
    if (rst_n && settled && !done)
      check("R9 live mode/power", (pwr_mode << 8) | mode_out, (m_pm << 8) | m_active);
  end

  task automatic wait_half();
    repeat (H) @(negedge clk);
  endtask

  task automatic bit_out(input bit b);
    sclk = 1'b1; sdata_in = b; wait_half();
    sclk = 1'b0; wait_half();
  endtask

  task automatic ssc();
    sdata_in = 1'b1; wait_half();
    sdata_in = 1'b0; wait_half();
  endtask

  task automatic header(input int sid, input int cmd, input bit flip);
    int v;
    v = (sid << 8) | cmd;
    for (int i = 11; i >= 0; i--) bit_out((v >> i) & 1);
    bit_out(even_ones(v, 12) ^ flip);
  endtask

  task automatic do_write(input int sid, input int a, input int d, input bit cf, input bit df);
    settled = 1'b0;
    ssc();
    header(sid, 'h40 | a, cf);
    for (int i = 7; i >= 0; i--) bit_out((d >> i) & 1);
    bit_out(even_ones(d, 8) ^ df);
    bit_out(1'b0);
    wait_half();
    if (!cf && !df && ((sid == m_usid && sid != 0) || (sid == 0 && a == 28))) apply(a, d);
    settled = 1'b1;
  endtask

  task automatic do_reg0(input int sid, input int d, input bit cf);
    settled = 1'b0;
    ssc();
    header(sid, 'h80 | d, cf);
    bit_out(1'b0);
    wait_half();
    if (!cf && sid == m_usid && sid != 0) apply(0, d);
    settled = 1'b1;
  endtask

  task automatic do_read(input int sid, input int a, output int data, output int pbit,
                         output int oe_cnt, output int park_ok, output int rel_ok);
    settled = 1'b0;
    ssc();
    header(sid, 'h60 | a, 1'b0);
    bit_out(1'b0);
    data = 0; pbit = 0; oe_cnt = 0;
    for (int i = 0; i < 9; i++) begin
      sclk = 1'b1; sdata_in = 1'b0; wait_half();
      oe_cnt += sdata_oe;
      if (i < 8) data = (data << 1) | sdata_out;
      else pbit = sdata_out;
      sclk = 1'b0; wait_half();
    end
    sclk = 1'b1; wait_half();
    park_ok = (sdata_oe && !sdata_out) ? 1 : 0;
    sclk = 1'b0; wait_half();
    rel_ok = sdata_oe ? 0 : 1;
    settled = 1'b1;
  endtask

  task automatic rd_chk(input string req, input int sid, input int a);
    int d, p, oe, pk, rl, e;
    e = exp_read(a);
    do_read(sid, a, d, p, oe, pk, rl);
    check({req, " read data"}, d, e);
    check("R7 read parity bit", p, even_ones(e, 8));
    check("R7 driven bit count", oe, 9);
    check("R7 park cycle driven low", pk, 1);
    check("R7 release after park", rl, 1);
  endtask

  initial begin
    int d, p, oe, pk, rl;
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 reset mode_out", mode_out, 0);
    check("R10 reset power mode", pwr_mode, 2);
    check("R10 reset line released", sdata_oe, 0);
    settled = 1'b1;

    rd_chk("R10 id register", 10, 31);
    rd_chk("R10 product id", 10, 29);
    rd_chk("R10 manufacturer id", 10, 30);
    rd_chk("R10 power/trigger", 10, 28);

    // shadow then trigger
    do_write(10, 0, 'h2A, 0, 0);
    check("R9 shadow holds mode", mode_out, 0);
    rd_chk("R9 active before trigger", 10, 0);
    do_write(10, 28, 'h81, 0, 0);
    check("R9 trigger applies shadow", mode_out, 'h2A);
    rd_chk("R9 trigger bits read zero", 10, 28);

    // masked: register-0 write goes through at once
    do_write(10, 28, 'h88, 0, 0);
    do_reg0(10, 'h05, 0);
    check("R6 register-0 write", mode_out, 'h05);
    rd_chk("R6 register-0 readback", 10, 0);

    // rejected frames
    do_reg0(10, 'h33, 1);
    check("R4 header parity error", mode_out, 'h05);
    do_reg0(3, 'h33, 0);
    check("R4 id mismatch", mode_out, 'h05);
    do_write(10, 0, 'h44, 0, 1);
    check("R5 data parity error", mode_out, 'h05);
    do_write(10, 0, 'h6C, 0, 0);
    check("R5 register write", mode_out, 'h6C);

    // read-only identity register
    do_write(10, 29, 'h00, 0, 0);
    rd_chk("R11 product id unchanged", 10, 29);

    // live slave ID
    do_write(10, 31, 'h03, 0, 0);
    do_reg0(10, 'h12, 0);
    check("R3 old id ignored", mode_out, 'h6C);
    do_reg0(3, 'h12, 0);
    check("R3 new id accepted", mode_out, 'h12);
    rd_chk("R3 id register", 3, 31);

    // broadcast
    do_write(0, 28, 'h48, 0, 0);
    check("R8 broadcast power mode", pwr_mode, 1);
    do_write(0, 0, 'h77, 0, 0);
    check("R8 broadcast write ignored", mode_out, 'h12);
    do_reg0(0, 'h77, 0);
    check("R8 broadcast register-0 ignored", mode_out, 'h12);
    do_read(0, 31, d, p, oe, pk, rl);
    check("R8 broadcast read not driven", oe + pk, 0);

    // data pulse with clock high is no start
    settled = 1'b0;
    sclk = 1'b1; sdata_in = 1'b1; wait_half();
    sdata_in = 1'b0; wait_half();
    sclk = 1'b0; wait_half();
    header(3, 'h80 | 'h21, 0);
    bit_out(1'b0);
    wait_half();
    settled = 1'b1;
    check("R1 no start without condition", mode_out, 'h12);

    // bit order
    do_write(3, 0, 'h5C, 0, 0);
    check("R2 msb-first write", mode_out, 'h5C);
    rd_chk("R2 msb-first read", 3, 0);

    // supply loss
    settled = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    settled = 1'b1;
    check("R10 mode after supply loss", mode_out, 0);
    check("R10 power mode after supply loss", pwr_mode, 2);
    rd_chk("R10 id after supply loss", 10, 31);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1'b1;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule